// File: doc/BRIEF.md
# Dual Amplifier Control Registers and Switch Decoder

This block holds the configuration and offset-trim state for a set of analog amplifier channels, two by default, and turns that state into the digital control lines of the analog macro. The lines close switches for the plus-input source, the minus-input source, the internal follower feedback and the gain-network tap, and enable the output pad. For each channel the block also drives a P and an N trim code onto a trim bus. It picks these codes from the user trim registers for the active power mode or from factory values.

Software reaches the block through a word-addressed synchronous port. Writes take effect at the clock edge on which they are presented. Read data comes back registered one cycle after the read strobe, with a valid flag. Each channel occupies a 16-byte window holding three words: control at +0x0, normal-mode trim at +0x4 and low-power trim at +0x8. Channel 0 sits at 0x00 and channel 1 at 0x10. The analog comparator result used during offset calibration enters as one bit per channel. It is synchronised and can be read back.

Top module: `amp_ctrl_regs`

## Requirements
- R1: After reset all control words read 0. Each trim word reads its factory value, which is loaded from `factory_trim`. Every switch and pad enable is off, `supply_hi` is 0, and the trim bus carries the factory normal-mode codes.
- R2: With the enable bit (control bit 0) at 0, every switch of the channel is open and its `pad_en` is 0.
- R3: With the calibration bit (control bit 12) at 1, every switch and the pad of the channel are open, whatever the mode and select fields hold. `cal_mode` is 1 and `cal_sel` follows control bit 13.
- R4: The mode field (bits 3:2) decodes as follows. Codes 00 and 01 leave the gain network off. Code 10 closes exactly one gain tap, `gain_tap[4c+g]`, where g is the gain field (bits 5:4), with 00=x2, 01=x4, 10=x8 and 11=x16. Code 11 closes the follower feedback and no tap.
- R5: The plus-input select (bit 6) routes the GPIO pin when 0 and the DAC when 1. At most one plus source is closed.
- R6: The minus-input select (bits 8:7) routes the GPIO pin for 00 and the dedicated low-leakage input for 01. For 1x it connects nothing. In follower mode both minus switches stay open.
- R7: The supply-range bit (bit 31 of the word at 0x00) changes on a write only if every channel was disabled before that write. Otherwise the write leaves it unchanged. It drives `supply_hi`.
- R8: A write can change the low-power bit (control bit 1) only if that channel's enable bit was 0 before the write. The other fields of the same write still take effect.
- R9: Each trim word holds P in bits 12:8 and N in bits 4:0. When the user-trim bit (control bit 14) is 1, the trim bus carries the low-power trim word if bit 1 is set and the normal trim word otherwise. When it is 0, the bus carries the factory codes for the active power mode.
- R10: Control bit 15 is read-only. It reads the synchronised comparator input while calibration is on and 0 otherwise. Writes to it have no effect.
- R11: Read data appears one cycle after `bus_rd`, with `bus_rvalid` high. Reserved bits read 0 and ignore writes. Offsets +0xC and unaligned addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 5 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after `bus_rd` |
| factory_trim | input | 40 | Per channel (20 bits): {lp P, lp N, normal P, normal N} |
| cal_cmp | input | 2 | Calibration comparator result per channel |
| supply_hi | output | 1 | Supply-range select |
| pad_en | output | 2 | Output pad enable |
| vp_gpio | output | 2 | Plus input from GPIO |
| vp_dac | output | 2 | Plus input from DAC |
| vm_gpio | output | 2 | Minus input from GPIO |
| vm_dedic | output | 2 | Minus input from dedicated low-leakage pin |
| follow_en | output | 2 | Internal follower feedback |
| gain_tap | output | 8 | One-hot gain tap per channel (x2, x4, x8, x16) |
| lowpwr | output | 2 | Low-power mode select |
| cal_mode | output | 2 | Channel enabled and in calibration |
| cal_sel | output | 2 | Calibration pair select |
| trim_p | output | 10 | P trim code per channel |
| trim_n | output | 10 | N trim code per channel |

## Verification
The assertions take for granted that reset is held low across at least one clock edge before any bus traffic. They also take for granted that `bus_rd` is never raised during reset, so the read-valid relation starts from a defined state. The comparator input is asynchronous. The properties never relate it to the read data directly, and the stimulus holds it steady for several cycles before each read of bit 15. The stimulus drives every strobe and address away from the active edge, and issues one read per cycle at most, so each result leaves the port in strict request order.

// File: rtl/amp_ctrl_pkg.sv
// Package: shared field positions, register selectors, mode encodings and the
// configuration and routing structures used by the amplifier control block.
// Assumes a 32-bit register word and trim codes of at most 5 bits.
package amp_ctrl_pkg;

    localparam int WORD_W   = 32;
    localparam int NTAPS    = 4;

    // control word bit positions
    localparam int B_EN     = 0;
    localparam int B_LP     = 1;
    localparam int B_MODE   = 2;
    localparam int B_GAIN   = 4;
    localparam int B_VP     = 6;
    localparam int B_VM     = 7;
    localparam int B_CALON  = 12;
    localparam int B_CALSEL = 13;
    localparam int B_USER   = 14;
    localparam int B_CALOUT = 15;
    localparam int B_RANGE  = 31;

    // trim word field positions
    localparam int B_TRIM_N = 0;
    localparam int B_TRIM_P = 8;

    // word selector inside a channel window (address bits 3:2)
    localparam logic [1:0] REG_CTRL  = 2'd0;
    localparam logic [1:0] REG_NTRIM = 2'd1;
    localparam logic [1:0] REG_LTRIM = 2'd2;

    typedef enum logic [1:0] {
        MD_PLAIN0 = 2'b00,
        MD_PLAIN1 = 2'b01,
        MD_GAIN   = 2'b10,
        MD_FOLLOW = 2'b11
    } amp_mode_e;

    typedef enum logic [1:0] {
        VM_GPIO  = 2'b00,
        VM_DEDIC = 2'b01,
        VM_OPEN0 = 2'b10,
        VM_OPEN1 = 2'b11
    } vm_src_e;

    typedef struct packed {
        logic       user_trim;
        logic       cal_sel;
        logic       cal_on;
        vm_src_e    vm_src;
        logic       vp_dac;
        logic [1:0] gain;
        amp_mode_e  mode;
        logic       lowpwr;
        logic       en;
    } chan_cfg_t;

    typedef struct packed {
        logic             pad;
        logic             vp_gpio;
        logic             vp_dac;
        logic             vm_gpio;
        logic             vm_dedic;
        logic             follow;
        logic [NTAPS-1:0] tap;
    } route_t;

    // extract the writable control fields from a bus word
    function automatic chan_cfg_t cfg_unpack(input logic [WORD_W-1:0] w);
        chan_cfg_t c;
        c.en        = w[B_EN];
        c.lowpwr    = w[B_LP];
        c.mode      = amp_mode_e'(w[B_MODE +: 2]);
        c.gain      = w[B_GAIN +: 2];
        c.vp_dac    = w[B_VP];
        c.vm_src    = vm_src_e'(w[B_VM +: 2]);
        c.cal_on    = w[B_CALON];
        c.cal_sel   = w[B_CALSEL];
        c.user_trim = w[B_USER];
        return c;
    endfunction

    // place the control fields back at their bus positions, reserved bits zero
    function automatic logic [WORD_W-1:0] cfg_pack(input chan_cfg_t c);
        logic [WORD_W-1:0] w;
        w                = '0;
        w[B_EN]          = c.en;
        w[B_LP]          = c.lowpwr;
        w[B_MODE +: 2]   = c.mode;
        w[B_GAIN +: 2]   = c.gain;
        w[B_VP]          = c.vp_dac;
        w[B_VM +: 2]     = c.vm_src;
        w[B_CALON]       = c.cal_on;
        w[B_CALSEL]      = c.cal_sel;
        w[B_USER]        = c.user_trim;
        return w;
    endfunction

endpackage

// File: rtl/amp_chan_regs.sv
// Module: per-channel register set. Holds the control fields, the normal-mode
// and low-power trim pairs and the comparator synchroniser. The low-power bit
// is write-locked while the channel is enabled. Trim pairs load the factory
// codes on reset. Assumes SYNC_STAGES >= 2 and TRIM_W <= 5.
module amp_chan_regs
    import amp_ctrl_pkg::*;
#(
    parameter  int TRIM_W      = 5,
    parameter  int SYNC_STAGES = 2,
    localparam int PAIR_W      = 2 * TRIM_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic              wr_ntrim,
    input  logic              wr_ltrim,
    input  logic [WORD_W-1:0] wdata,
    input  logic [PAIR_W-1:0] fac_norm,
    input  logic [PAIR_W-1:0] fac_lowp,
    input  logic              cal_cmp,
    output chan_cfg_t         cfg,
    output logic [PAIR_W-1:0] ntrim,
    output logic [PAIR_W-1:0] ltrim,
    output logic              cal_out
);

    chan_cfg_t              cfg_q;
    chan_cfg_t              cfg_wr;
    logic [PAIR_W-1:0]      ntrim_q;
    logic [PAIR_W-1:0]      ltrim_q;
    logic [PAIR_W-1:0]      trim_wr;
    logic [SYNC_STAGES-1:0] sync_q;

    // next control value of a write, keeping the power mode while enabled
    always_comb begin
        cfg_wr = cfg_unpack(wdata);
        if (cfg_q.en) begin
            cfg_wr.lowpwr = cfg_q.lowpwr;
        end
    end

    // trim pair as {P, N} taken from the bus word
    assign trim_wr = {wdata[B_TRIM_P +: TRIM_W], wdata[B_TRIM_N +: TRIM_W]};

    // control register update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_ctrl) begin
            cfg_q <= cfg_wr;
        end
    end

    // trim registers, loaded with factory codes on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ntrim_q <= fac_norm;
            ltrim_q <= fac_lowp;
        end else begin
            if (wr_ntrim) ntrim_q <= trim_wr;
            if (wr_ltrim) ltrim_q <= trim_wr;
        end
    end

    // comparator synchroniser chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], cal_cmp};
        end
    end

    assign cfg     = cfg_q;
    assign ntrim   = ntrim_q;
    assign ltrim   = ltrim_q;
    assign cal_out = cfg_q.cal_on & sync_q[SYNC_STAGES-1];

endmodule

// File: rtl/amp_route_dec.sv
// Module: combinational switch decoder for one channel. It turns the enable,
// calibration, mode and source fields into switch and pad enables. Closing
// any switch requires enable on and calibration off.
module amp_route_dec
    import amp_ctrl_pkg::*;
(
    input  chan_cfg_t cfg,
    output route_t    rt
);

    logic             live;
    logic             gain_on;
    logic             ext_minus;
    logic [NTAPS-1:0] tap_v;

    assign live      = cfg.en & ~cfg.cal_on;
    assign gain_on   = live & (cfg.mode == MD_GAIN);
    assign ext_minus = live & (cfg.mode != MD_FOLLOW);

    // one tap per gain code
    for (genvar t = 0; t < NTAPS; t++) begin : g_tap
        assign tap_v[t] = gain_on & (cfg.gain == 2'(t));
    end

    // gather the switch enables
    always_comb begin
        rt.pad      = live;
        rt.vp_gpio  = live & ~cfg.vp_dac;
        rt.vp_dac   = live &  cfg.vp_dac;
        rt.vm_gpio  = ext_minus & (cfg.vm_src == VM_GPIO);
        rt.vm_dedic = ext_minus & (cfg.vm_src == VM_DEDIC);
        rt.follow   = live & (cfg.mode == MD_FOLLOW);
        rt.tap      = tap_v;
    end

endmodule

// File: rtl/amp_trim_sel.sv
// Module: trim-code selector for one channel. User trim pairs are chosen by
// the power mode when user trim is on. Otherwise the factory pair for the
// power mode drives the bus.
module amp_trim_sel
    import amp_ctrl_pkg::*;
#(
    parameter  int TRIM_W = 5,
    localparam int PAIR_W = 2 * TRIM_W
) (
    input  chan_cfg_t         cfg,
    input  logic [PAIR_W-1:0] ntrim,
    input  logic [PAIR_W-1:0] ltrim,
    input  logic [PAIR_W-1:0] fac_norm,
    input  logic [PAIR_W-1:0] fac_lowp,
    output logic [TRIM_W-1:0] trim_p,
    output logic [TRIM_W-1:0] trim_n
);

    logic [PAIR_W-1:0] pick;

    // choose source pair from trim origin and power mode
    always_comb begin
        case ({cfg.user_trim, cfg.lowpwr})
            2'b11:   pick = ltrim;
            2'b10:   pick = ntrim;
            2'b01:   pick = fac_lowp;
            default: pick = fac_norm;
        endcase
    end

    assign trim_p = pick[TRIM_W +: TRIM_W];
    assign trim_n = pick[0 +: TRIM_W];

endmodule

// File: rtl/amp_ctrl_regs.sv
// Module: top of the amplifier control block. Decodes the word-addressed bus,
// holds the shared supply-range bit, instantiates one register set, switch
// decoder and trim selector per channel, and returns registered read data.
// Assumes NCH >= 2 and a 16-byte window per channel.
module amp_ctrl_regs
    import amp_ctrl_pkg::*;
#(
    parameter  int NCH         = 2,
    parameter  int TRIM_W      = 5,
    parameter  int SYNC_STAGES = 2,
    localparam int CH_W        = $clog2(NCH),
    localparam int ADDR_W      = CH_W + 4,
    localparam int PAIR_W      = 2 * TRIM_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_wr,
    input  logic                    bus_rd,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [WORD_W-1:0]       bus_wdata,
    output logic [WORD_W-1:0]       bus_rdata,
    output logic                    bus_rvalid,
    input  logic [NCH*2*PAIR_W-1:0] factory_trim,
    input  logic [NCH-1:0]          cal_cmp,
    output logic                    supply_hi,
    output logic [NCH-1:0]          pad_en,
    output logic [NCH-1:0]          vp_gpio,
    output logic [NCH-1:0]          vp_dac,
    output logic [NCH-1:0]          vm_gpio,
    output logic [NCH-1:0]          vm_dedic,
    output logic [NCH-1:0]          follow_en,
    output logic [NCH*NTAPS-1:0]    gain_tap,
    output logic [NCH-1:0]          lowpwr,
    output logic [NCH-1:0]          cal_mode,
    output logic [NCH-1:0]          cal_sel,
    output logic [NCH*TRIM_W-1:0]   trim_p,
    output logic [NCH*TRIM_W-1:0]   trim_n
);

    logic [CH_W-1:0]   addr_ch;
    logic [1:0]        addr_reg;
    logic              aligned;
    logic              range_q;
    logic              range_wr;
    logic [NCH-1:0]    ch_en;
    logic [NCH-1:0]    ch_cal;
    logic [NCH-1:0]    ch_lp;
    logic [WORD_W-1:0] ctrl_word  [NCH];
    logic [WORD_W-1:0] ntrim_word [NCH];
    logic [WORD_W-1:0] ltrim_word [NCH];
    logic [WORD_W-1:0] sel_word;

    assign addr_ch  = bus_addr[ADDR_W-1:4];
    assign addr_reg = bus_addr[3:2];
    assign aligned  = (bus_addr[1:0] == 2'b00);

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        chan_cfg_t         cfg;
        route_t            rt;
        logic [PAIR_W-1:0] ntrim;
        logic [PAIR_W-1:0] ltrim;
        logic [PAIR_W-1:0] fac_norm;
        logic [PAIR_W-1:0] fac_lowp;
        logic              cal_out;
        logic              hit;

        assign hit      = aligned & (addr_ch == CH_W'(i));
        assign fac_norm = factory_trim[i*2*PAIR_W +: PAIR_W];
        assign fac_lowp = factory_trim[i*2*PAIR_W + PAIR_W +: PAIR_W];

        amp_chan_regs #(
            .TRIM_W      (TRIM_W),
            .SYNC_STAGES (SYNC_STAGES)
        ) u_regs (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_ctrl  (bus_wr & hit & (addr_reg == REG_CTRL)),
            .wr_ntrim (bus_wr & hit & (addr_reg == REG_NTRIM)),
            .wr_ltrim (bus_wr & hit & (addr_reg == REG_LTRIM)),
            .wdata    (bus_wdata),
            .fac_norm (fac_norm),
            .fac_lowp (fac_lowp),
            .cal_cmp  (cal_cmp[i]),
            .cfg      (cfg),
            .ntrim    (ntrim),
            .ltrim    (ltrim),
            .cal_out  (cal_out)
        );

        amp_route_dec u_dec (
            .cfg (cfg),
            .rt  (rt)
        );

        amp_trim_sel #(
            .TRIM_W (TRIM_W)
        ) u_trim (
            .cfg      (cfg),
            .ntrim    (ntrim),
            .ltrim    (ltrim),
            .fac_norm (fac_norm),
            .fac_lowp (fac_lowp),
            .trim_p   (trim_p[i*TRIM_W +: TRIM_W]),
            .trim_n   (trim_n[i*TRIM_W +: TRIM_W])
        );

        // readable words of this channel
        always_comb begin
            ctrl_word[i]                      = cfg_pack(cfg);
            ctrl_word[i][B_CALOUT]            = cal_out;
            ctrl_word[i][B_RANGE]             = (i == 0) ? range_q : 1'b0;
            ntrim_word[i]                     = '0;
            ntrim_word[i][B_TRIM_P +: TRIM_W] = ntrim[TRIM_W +: TRIM_W];
            ntrim_word[i][B_TRIM_N +: TRIM_W] = ntrim[0 +: TRIM_W];
            ltrim_word[i]                     = '0;
            ltrim_word[i][B_TRIM_P +: TRIM_W] = ltrim[TRIM_W +: TRIM_W];
            ltrim_word[i][B_TRIM_N +: TRIM_W] = ltrim[0 +: TRIM_W];
        end

        assign ch_en[i]                   = cfg.en;
        assign ch_cal[i]                  = cfg.cal_on;
        assign ch_lp[i]                   = cfg.lowpwr;
        assign pad_en[i]                  = rt.pad;
        assign vp_gpio[i]                 = rt.vp_gpio;
        assign vp_dac[i]                  = rt.vp_dac;
        assign vm_gpio[i]                 = rt.vm_gpio;
        assign vm_dedic[i]                = rt.vm_dedic;
        assign follow_en[i]               = rt.follow;
        assign gain_tap[i*NTAPS +: NTAPS] = rt.tap;
        assign lowpwr[i]                  = cfg.lowpwr;
        assign cal_mode[i]                = cfg.en & cfg.cal_on;
        assign cal_sel[i]                 = cfg.cal_sel;
    end

    // supply range accepts a write only while every channel is off
    assign range_wr = bus_wr & aligned & (addr_ch == '0) &
                      (addr_reg == REG_CTRL) & ~|ch_en;

    // shared supply-range bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            range_q <= 1'b0;
        end else if (range_wr) begin
            range_q <= bus_wdata[B_RANGE];
        end
    end

    assign supply_hi = range_q;

    // read multiplexer over channels and word selectors
    always_comb begin
        sel_word = '0;
        for (int i = 0; i < NCH; i++) begin
            if (aligned && addr_ch == CH_W'(i)) begin
                case (addr_reg)
                    REG_CTRL:  sel_word = ctrl_word[i];
                    REG_NTRIM: sel_word = ntrim_word[i];
                    REG_LTRIM: sel_word = ltrim_word[i];
                    default:   sel_word = '0;
                endcase
            end
        end
    end

    // registered read return
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= bus_rd;
            if (bus_rd) bus_rdata <= sel_word;
        end
    end

endmodule

// File: rtl/amp_ctrl_chk.sv
// Module: property checker for amp_ctrl_regs, bound to every instance.
// It observes the switch outputs against the stored enable, calibration and
// power fields, together with the read handshake.
module amp_ctrl_chk #(
    parameter int NCH   = 2,
    parameter int NTAPS = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_rd,
    input logic                 bus_rvalid,
    input logic                 supply_hi,
    input logic [NCH-1:0]       ch_en,
    input logic [NCH-1:0]       ch_cal,
    input logic [NCH-1:0]       ch_lp,
    input logic [NCH-1:0]       pad_en,
    input logic [NCH-1:0]       vp_gpio,
    input logic [NCH-1:0]       vp_dac,
    input logic [NCH-1:0]       vm_gpio,
    input logic [NCH-1:0]       vm_dedic,
    input logic [NCH-1:0]       follow_en,
    input logic [NCH*NTAPS-1:0] gain_tap
);

    for (genvar i = 0; i < NCH; i++) begin : g_c
        logic any_sw;
        assign any_sw = pad_en[i] | vp_gpio[i] | vp_dac[i] | vm_gpio[i] |
                        vm_dedic[i] | follow_en[i] | (|gain_tap[i*NTAPS +: NTAPS]);

        a_r2_off_open: assert property (@(posedge clk) disable iff (!rst_n)
            !ch_en[i] |-> !any_sw);

        a_r3_cal_open: assert property (@(posedge clk) disable iff (!rst_n)
            ch_cal[i] |-> !any_sw);

        a_r4_tap_onehot: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0({gain_tap[i*NTAPS +: NTAPS], follow_en[i]}));

        a_r5_vp_single: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0({vp_gpio[i], vp_dac[i]}));

        a_r6_vm_single: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0({vm_gpio[i], vm_dedic[i], follow_en[i]}));

        a_r8_lp_locked: assert property (@(posedge clk) disable iff (!rst_n)
            ch_en[i] |=> $stable(ch_lp[i]));
    end

    a_r7_range_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (|ch_en) |=> $stable(supply_hi));

    a_r11_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid);

endmodule

bind amp_ctrl_regs amp_ctrl_chk #(
    .NCH   (NCH),
    .NTAPS (4)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_rd     (bus_rd),
    .bus_rvalid (bus_rvalid),
    .supply_hi  (supply_hi),
    .ch_en      (ch_en),
    .ch_cal     (ch_cal),
    .ch_lp      (ch_lp),
    .pad_en     (pad_en),
    .vp_gpio    (vp_gpio),
    .vp_dac     (vp_dac),
    .vm_gpio    (vm_gpio),
    .vm_dedic   (vm_dedic),
    .follow_en  (follow_en),
    .gain_tap   (gain_tap)
);

// File: tb/sim_amp_ctrl_regs.sv
`timescale 1ns/1ps
// Bench: scoreboard for amp_ctrl_regs. Read tasks queue expected words and a
// monitor compares returned data. Switch and trim outputs are checked directly.
module sim_amp_ctrl_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [39:0] factory_trim;
    logic [1:0]  cal_cmp = 2'b00;
    logic        supply_hi;
    logic [1:0]  pad_en, vp_gpio, vp_dac, vm_gpio, vm_dedic, follow_en;
    logic [7:0]  gain_tap;
    logic [1:0]  lowpwr, cal_mode, cal_sel;
    logic [9:0]  trim_p, trim_n;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [31:0] q_exp[$];
    string       q_tag[$];

    // ch1 {lpP,lpN,nP,nN}, ch0 {lpP,lpN,nP,nN}
    assign factory_trim = {5'h02, 5'h15, 5'h1F, 5'h00, 5'h11, 5'h07, 5'h0A, 5'h03};

    always #2.5 clk = ~clk;

    amp_ctrl_regs u0 (
        .clk (clk), .rst_n (rst_n), .bus_wr (bus_wr), .bus_rd (bus_rd),
        .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .bus_rvalid (bus_rvalid), .factory_trim (factory_trim), .cal_cmp (cal_cmp),
        .supply_hi (supply_hi), .pad_en (pad_en), .vp_gpio (vp_gpio), .vp_dac (vp_dac),
        .vm_gpio (vm_gpio), .vm_dedic (vm_dedic), .follow_en (follow_en),
        .gain_tap (gain_tap), .lowpwr (lowpwr), .cal_mode (cal_mode), .cal_sel (cal_sel),
        .trim_p (trim_p), .trim_n (trim_n)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // expected switch set {pad,vpg,vpd,vmg,vmd,fol,tap[3:0]} from a control word
    function automatic logic [9:0] exp_route(input logic [31:0] w);
        logic live;
        live = w[0] & ~w[12];
        return {live, live & ~w[6], live & w[6],
                live & (w[3:2] != 2'b11) & (w[8:7] == 2'b00),
                live & (w[3:2] != 2'b11) & (w[8:7] == 2'b01),
                live & (w[3:2] == 2'b11),
                (live && w[3:2] == 2'b10) ? (4'b0001 << w[5:4]) : 4'b0000};
    endfunction

    function automatic logic [9:0] act_route(input int c);
        return {pad_en[c], vp_gpio[c], vp_dac[c], vm_gpio[c], vm_dedic[c],
                follow_en[c], gain_tap[c*4 +: 4]};
    endfunction

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        q_exp.push_back(exp);
        q_tag.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // monitor: compare returned read data against the queue
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (q_exp.size() == 0) begin
                check("R11 unexpected rvalid", 64'(bus_rvalid), 64'd0);
            end else begin
                check(q_tag.pop_front(), 64'(bus_rdata), 64'(q_exp.pop_front()));
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 switches", 64'({act_route(1), act_route(0)}), 64'd0);
        check("R1 supply_hi", 64'(supply_hi), 64'd0);
        check("R1 trim_p", 64'(trim_p), 64'({5'h1F, 5'h0A}));
        check("R1 trim_n", 64'(trim_n), 64'({5'h00, 5'h03}));
        check("R1 rvalid", 64'(bus_rvalid), 64'd0);
        bus_read(5'h00, 32'h0, "R1 ctrl0");
        bus_read(5'h04, 32'h0A03, "R1 ntrim0");
        bus_read(5'h08, 32'h1107, "R1 ltrim0");
        bus_read(5'h10, 32'h0, "R1 ctrl1");
        bus_read(5'h14, 32'h1F00, "R1 ntrim1");
        bus_read(5'h18, 32'h0215, "R1 ltrim1");

        // R5/R7: enable with DAC plus input and set range while all off
        bus_write(5'h00, 32'h8000_0041);
        check("R5 dac route", 64'(act_route(0)), 64'(exp_route(32'h41)));
        check("R7 range set", 64'(supply_hi), 64'd1);
        bus_read(5'h00, 32'h8000_0041, "R7 ctrl0 range");

        // R7/R8: range and low-power ignored while enabled
        bus_write(5'h00, 32'h0000_0043);
        check("R8 lp locked", 64'(lowpwr[0]), 64'd0);
        check("R7 range locked", 64'(supply_hi), 64'd1);
        bus_read(5'h00, 32'h8000_0041, "R8 ctrl0 readback");

        // R4/R6: gain mode, minus input open, every gain code
        for (int g = 0; g < 4; g++) begin
            bus_write(5'h00, 32'h109 | (32'(g) << 4));
            check("R4 gain tap", 64'(act_route(0)), 64'(exp_route(32'h109 | (32'(g) << 4))));
            check("R6 vm open", 64'({vm_gpio[0], vm_dedic[0]}), 64'd0);
        end
        bus_read(5'h00, 32'h8000_0139, "R4 ctrl0 gain");

        // R4/R6: follower with dedicated select keeps minus open
        bus_write(5'h00, 32'h0000_008D);
        check("R4 follower", 64'(act_route(0)), 64'(exp_route(32'h8D)));
        check("R6 follower vm", 64'({vm_dedic[0], follow_en[0]}), 64'b01);

        // R6: plain mode 01 with dedicated input
        bus_write(5'h00, 32'h0000_0085);
        check("R6 dedicated", 64'(act_route(0)), 64'(exp_route(32'h85)));

        // R3/R10: calibration opens everything, comparator visible
        bus_write(5'h00, 32'h0000_3001);
        check("R3 cal open", 64'(act_route(0)), 64'd0);
        check("R3 cal flags", 64'({cal_mode[0], cal_sel[0]}), 64'b11);
        cal_cmp[0] = 1'b1;
        repeat (4) @(negedge clk);
        bus_read(5'h00, 32'h8000_B001, "R10 calout high");
        cal_cmp[0] = 1'b0;
        repeat (4) @(negedge clk);
        bus_read(5'h00, 32'h8000_3001, "R10 calout low");

        // R10: calout reads 0 outside calibration, write ignored
        cal_cmp[0] = 1'b1;
        bus_write(5'h00, 32'h0000_8001);
        repeat (4) @(negedge clk);
        check("R2 plain route", 64'(act_route(0)), 64'(exp_route(32'h1)));
        bus_read(5'h00, 32'h8000_0001, "R10 calout off");
        cal_cmp[0] = 1'b0;

        // R2/R7: disable; range blocked on this write, accepted on next
        bus_write(5'h00, 32'h0000_0000);
        check("R2 disabled open", 64'(act_route(0)), 64'd0);
        check("R7 range held", 64'(supply_hi), 64'd1);
        bus_write(5'h00, 32'h0000_0000);
        check("R7 range cleared", 64'(supply_hi), 64'd0);

        // R9/R11: user trims with reserved bits set
        bus_write(5'h04, 32'hFFFF_F5E5);
        bus_write(5'h08, 32'hABCD_EC1E);
        bus_read(5'h04, 32'h0000_1505, "R11 ntrim reserved");
        bus_read(5'h08, 32'h0000_0C1E, "R11 ltrim reserved");
        check("R9 factory still", 64'({trim_p[4:0], trim_n[4:0]}), 64'({5'h0A, 5'h03}));
        bus_write(5'h00, 32'h0000_4002);
        check("R8 lp accepted", 64'(lowpwr[0]), 64'd1);
        check("R9 user lp", 64'({trim_p[4:0], trim_n[4:0]}), 64'({5'h0C, 5'h1E}));
        bus_write(5'h00, 32'h0000_4000);
        check("R9 user normal", 64'({trim_p[4:0], trim_n[4:0]}), 64'({5'h15, 5'h05}));
        bus_write(5'h00, 32'h0000_0002);
        check("R9 factory lp", 64'({trim_p[4:0], trim_n[4:0]}), 64'({5'h11, 5'h07}));

        // ch1: gain x16; bit31 reserved there; range blocked by ch1
        bus_write(5'h10, 32'h8000_0139);
        check("R4 ch1 x16", 64'(act_route(1)), 64'(exp_route(32'h139)));
        check("R2 ch0 idle", 64'(act_route(0)), 64'd0);
        bus_read(5'h10, 32'h0000_0139, "R11 ch1 bit31 reserved");
        bus_write(5'h00, 32'h8000_0002);
        check("R7 blocked by ch1", 64'(supply_hi), 64'd0);
        bus_read(5'h00, 32'h0000_0002, "R7 ctrl0 no range");

        // R11: unmapped and unaligned offsets; ch1 trims untouched
        bus_read(5'h0C, 32'h0, "R11 unmapped 0C");
        bus_read(5'h1C, 32'h0, "R11 unmapped 1C");
        bus_read(5'h11, 32'h0, "R11 unaligned");
        bus_read(5'h14, 32'h1F00, "R9 ch1 ntrim kept");
        bus_read(5'h18, 32'h0215, "R9 ch1 ltrim kept");

        repeat (3) @(negedge clk);
        check("R11 queue drained", 64'(q_exp.size()), 64'd0);
        finish_run();
    end

endmodule